// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is one DMA channel that takes its orders from a chain of descriptors held in memory. Software places the address of the first descriptor in the list address register. Writing the top byte of that register starts the channel. The channel then asks for the bus and reads the 8-byte descriptor with four 16-bit accesses.

Each descriptor carries a 24-bit buffer address, a type/status byte and a 16-bit length. The type byte chooses what happens next: stop, jump to another descriptor, or serve a ready buffer. A ready buffer may carry a 6-bit command for the client, and it may ask for an end-of-buffer notice. The channel marks such a descriptor as busy. It then moves the buffer one byte per request/acknowledge pair, in the direction chosen by the client's direction pin. When the buffer is done, the channel writes a completion code back into the type byte and moves on to the next descriptor, 8 bytes further on.

Top module: `ll_dma_channel`

## Requirements
- R1: After reset, `run`, `bus_req`, `mem_rd`, `mem_wr`, `dev_ack`, `dev_typefetch`, `dev_eob` and `dev_store` are all 0.
- R2: The list address register has three byte lanes: `reg_sel` 0 selects bits 7..0, 1 selects bits 15..8 and 2 selects bits 23..16. Bits 2..0 are always zero. A write to lane 2 sets `run` on the next cycle, and `bus_req` follows `run`. The first descriptor is fetched from the register address with its low three bits cleared.
- R3: A descriptor is read with four 16-bit accesses (`mem_wide`=1) at offsets 0, 2, 4 and 6. The data is little-endian. Word 0 holds buffer address bits 15..0. The low byte of word 1 holds address bits 23..16. The low byte of word 2 is the type code. Word 3 is the length. Every 16-bit access uses an even address.
- R4: A type code of 00, or any code outside 01, 02, 03 and 40..BF, ends the chain. `run` and `bus_req` drop, no write-back is made and there is no further memory cycle.
- R5: Type 01 is a link. The next descriptor is fetched from the descriptor's address field with its low three bits cleared. The link descriptor itself is not rewritten.
- R6: For a ready buffer (02, 03, 40..BF), the channel writes the 16-bit value 0x0004 at offset 4, in the same cycle as a one-cycle `dev_typefetch` pulse. During that pulse `dev_cmd` equals type bits 5..0 for codes 40..BF and 0 for codes 02 and 03.
- R7: Each `dev_ack` answers a `dev_req` in the same cycle. It moves one byte at the current buffer address, and the address rises by one per byte. With `xfer_to_dev`=1, memory is read and the byte appears on `dev_wdata`. With `xfer_to_dev`=0, `dev_rdata` is written to memory.
- R8: A buffer of length N gives exactly N acknowledges. A length of 0 gives none.
- R9: `dev_eob` is asserted together with the final acknowledge of a buffer, and only for codes 03 and 80..BF.
- R10: When `dev_term` is high while the channel waits for data, the buffer ends in that cycle with no acknowledge.
- R11: When a buffer ends, `dev_store` is high until a 16-bit write at offset 4 is granted. The value written is 0x0005 if `dev_status[6]` is 0. Otherwise it is 0x00C0 OR `dev_status[5:0]`. The next descriptor is then fetched at the list address plus 8.
- R12: Writes to the list address register while `run` is 1 are ignored.
- R13: No memory cycle happens while `bus_gnt` is 0. The channel waits and then continues without losing or repeating any access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | List address register write strobe |
| reg_sel | input | 2 | Byte lane of the register write |
| reg_wdata | input | 8 | Register write data |
| run | output | 1 | Channel Run bit |
| xfer_to_dev | input | 1 | 1: memory to client, 0: client to memory |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_addr | output | 24 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wide | output | 1 | 1: 16-bit access, 0: byte access |
| mem_wdata | output | 16 | Memory write data (byte access uses bits 7..0) |
| mem_rdata | input | 16 | Memory read data, valid in the cycle of the read |
| dev_req | input | 1 | Client data request |
| dev_term | input | 1 | Client terminate |
| dev_typefetch | output | 1 | Type fetch pulse |
| dev_cmd | output | 6 | Command bits shown during type fetch |
| dev_ack | output | 1 | Data acknowledge |
| dev_eob | output | 1 | End of buffer |
| dev_store | output | 1 | Store status request |
| dev_status | input | 7 | Bit 6: status valid, bits 5..0: status |
| dev_wdata | output | 8 | Data to client |
| dev_rdata | input | 8 | Data from client |

## Verification
Any fault in the descriptor pointer shows up at the address of the next 16-bit fetch, which the bench logs as the address of every offset-0 read. A bad length or address counter shows up within one buffer, as a wrong number of acknowledges or as bytes out of place in the copied area. A wrong decision on the type byte shows up within a few cycles, as a missing or extra type fetch pulse, a wrong command, a misplaced end-of-buffer, or a wrong code in the written-back type byte. The sweep covers every length from 0 to 5, both directions and four type classes, so off-by-one faults at the start and at the end of a buffer are seen at the ports.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

    localparam int PKG_ADDR_W     = 24;
    localparam int PKG_LEN_W      = 16;
    localparam int PKG_WORD_W     = 16;
    localparam int PKG_DESC_BYTES = 8;

    // word offsets inside a descriptor
    localparam logic [2:0] OFS_ADDR_LO = 3'd0;
    localparam logic [2:0] OFS_ADDR_HI = 3'd2;
    localparam logic [2:0] OFS_TYPE    = 3'd4;
    localparam logic [2:0] OFS_LEN     = 3'd6;

    localparam logic [7:0] TC_END      = 8'h00;
    localparam logic [7:0] TC_LINK     = 8'h01;
    localparam logic [7:0] TC_RDY      = 8'h02;
    localparam logic [7:0] TC_RDY_EOB  = 8'h03;
    localparam logic [7:0] TC_BUSY     = 8'h04;
    localparam logic [7:0] TC_DONE     = 8'h05;
    localparam logic [7:0] TC_STAT     = 8'hC0;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD0,
        S_RD1,
        S_RD2,
        S_RD3,
        S_MARK,
        S_XFER,
        S_STORE
    } seq_state_t;

    typedef enum logic [1:0] {
        ACT_END,
        ACT_LINK,
        ACT_BUF
    } desc_act_t;

    typedef struct packed {
        desc_act_t  act;
        logic       notify;
        logic       has_cmd;
        logic [5:0] cmd;
    } desc_decode_t;

    function automatic desc_decode_t decode_type(input logic [7:0] t);
        desc_decode_t d;
        d.act     = ACT_END;
        d.notify  = 1'b0;
        d.has_cmd = 1'b0;
        d.cmd     = t[5:0];
        if (t == TC_LINK) begin
            d.act = ACT_LINK;
        end else if (t == TC_RDY || t == TC_RDY_EOB) begin
            d.act    = ACT_BUF;
            d.notify = t[0];
        end else if (t[7:6] == 2'b01 || t[7:6] == 2'b10) begin
            d.act     = ACT_BUF;
            d.has_cmd = 1'b1;
            d.notify  = t[7];
        end
        return d;
    endfunction

    function automatic logic [7:0] done_code(input logic [6:0] stat);
        return stat[6] ? (TC_STAT | {2'b00, stat[5:0]}) : TC_DONE;
    endfunction

endpackage

// File: rtl/lldma_lar.sv
module lldma_lar #(
    parameter int ADDR_W = 24,
    parameter int ALIGN  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              link_load,
    input  logic [ADDR_W-1:ALIGN] link_addr,
    input  logic              advance,
    input  logic              stop,
    output logic [ADDR_W-1:ALIGN] list_hi,
    output logic              run
);
    localparam int NLANES = (ADDR_W + 7) / 8;
    localparam int PTR_W  = ADDR_W - ALIGN;
    localparam logic [PTR_W-1:0] PTR_ONE = 1;

    logic [ADDR_W-1:ALIGN] lar_q;
    logic                  run_q;

    wire unused_lowbits = ^reg_wdata[ALIGN-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            lar_q <= '0;
            run_q <= 1'b0;
        end else begin
            if (reg_we && !run_q) begin
                for (int i = ALIGN; i < ADDR_W; i++) begin
                    if ((i / 8) == int'(reg_sel)) begin
                        lar_q[i] <= reg_wdata[i % 8];
                    end
                end
                if (int'(reg_sel) == NLANES - 1) begin
                    run_q <= 1'b1;
                end
            end else if (link_load) begin
                lar_q <= link_addr;
            end else if (advance) begin
                lar_q <= lar_q + PTR_ONE;
            end
            if (stop) begin
                run_q <= 1'b0;
            end
        end
    end

    assign list_hi = lar_q;
    assign run     = run_q;

endmodule

// File: rtl/lldma_bufctr.sv
module lldma_bufctr #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              ld_len,
    input  logic              step,
    input  logic [WORD_W-1:0] word_in,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [LEN_W-1:0]  remain
);
    localparam int HI_W = ADDR_W - WORD_W;
    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
    localparam logic [LEN_W-1:0]  LEN_ONE  = 1;

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;

    wire unused_hibyte = ^word_in[WORD_W-1:HI_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            len_q  <= '0;
        end else begin
            if (ld_lo) begin
                addr_q[WORD_W-1:0] <= word_in;
            end else if (ld_hi) begin
                addr_q[ADDR_W-1:WORD_W] <= word_in[HI_W-1:0];
            end else if (step) begin
                addr_q <= addr_q + ADDR_ONE;
            end
            if (ld_len) begin
                len_q <= word_in[LEN_W-1:0];
            end else if (step) begin
                len_q <= len_q - LEN_ONE;
            end
        end
    end

    assign buf_addr = addr_q;
    assign remain   = len_q;

endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
    import lldma_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int ALIGN  = 3,
    parameter int LEN_W  = 16,
    parameter int WORD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic [ADDR_W-1:ALIGN] list_hi,
    input  logic [ADDR_W-1:0]     buf_addr,
    input  logic [LEN_W-1:0]      remain,
    input  logic                  xfer_to_dev,
    input  logic                  bus_gnt,
    input  logic [7:0]            rd_byte,
    input  logic                  dev_req,
    input  logic                  dev_term,
    input  logic [6:0]            dev_status,
    input  logic [7:0]            dev_rdata,
    output logic                  bus_req,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic                  mem_wide,
    output logic [WORD_W-1:0]     mem_wdata,
    output logic                  dev_typefetch,
    output logic [5:0]            dev_cmd,
    output logic                  dev_ack,
    output logic                  dev_eob,
    output logic                  dev_store,
    output logic [7:0]            dev_wdata,
    output logic                  ld_lo,
    output logic                  ld_hi,
    output logic                  ld_len,
    output logic                  step,
    output logic                  link_load,
    output logic                  advance,
    output logic                  stop
);
    localparam logic [LEN_W-1:0] LEN_ONE = 1;

    seq_state_t   st_q, st_d;
    logic [7:0]   type_q;
    desc_decode_t dec;
    logic         last_byte;

    assign dec       = decode_type(type_q);
    assign last_byte = (remain == LEN_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            type_q <= TC_END;
        end else begin
            st_q <= st_d;
            if (st_q == S_RD2 && bus_gnt) begin
                type_q <= rd_byte;
            end
        end
    end

    always_comb begin
        st_d          = st_q;
        bus_req       = run;
        mem_addr      = '0;
        mem_rd        = 1'b0;
        mem_wr        = 1'b0;
        mem_wide      = 1'b1;
        mem_wdata     = '0;
        dev_typefetch = 1'b0;
        dev_cmd       = '0;
        dev_ack       = 1'b0;
        dev_eob       = 1'b0;
        dev_store     = 1'b0;
        dev_wdata     = '0;
        ld_lo         = 1'b0;
        ld_hi         = 1'b0;
        ld_len        = 1'b0;
        step          = 1'b0;
        link_load     = 1'b0;
        advance       = 1'b0;
        stop          = 1'b0;
        case (st_q)
            S_IDLE: begin
                if (run) st_d = S_RD0;
            end
            S_RD0: begin
                mem_addr = {list_hi, OFS_ADDR_LO};
                mem_rd   = bus_gnt;
                ld_lo    = bus_gnt;
                if (bus_gnt) st_d = S_RD1;
            end
            S_RD1: begin
                mem_addr = {list_hi, OFS_ADDR_HI};
                mem_rd   = bus_gnt;
                ld_hi    = bus_gnt;
                if (bus_gnt) st_d = S_RD2;
            end
            S_RD2: begin
                mem_addr = {list_hi, OFS_TYPE};
                mem_rd   = bus_gnt;
                if (bus_gnt) st_d = S_RD3;
            end
            S_RD3: begin
                mem_addr = {list_hi, OFS_LEN};
                mem_rd   = bus_gnt;
                ld_len   = bus_gnt;
                if (bus_gnt) begin
                    case (dec.act)
                        ACT_LINK: begin
                            link_load = 1'b1;
                            st_d      = S_RD0;
                        end
                        ACT_BUF: st_d = S_MARK;
                        default: begin
                            stop = 1'b1;
                            st_d = S_IDLE;
                        end
                    endcase
                end
            end
            S_MARK: begin
                mem_addr      = {list_hi, OFS_TYPE};
                mem_wr        = bus_gnt;
                mem_wdata     = {8'h00, TC_BUSY};
                dev_typefetch = bus_gnt;
                dev_cmd       = (bus_gnt && dec.has_cmd) ? dec.cmd : 6'd0;
                if (bus_gnt) st_d = (remain == '0) ? S_STORE : S_XFER;
            end
            S_XFER: begin
                if (dev_term) begin
                    st_d = S_STORE;
                end else if (dev_req && bus_gnt) begin
                    mem_addr  = buf_addr;
                    mem_wide  = 1'b0;
                    mem_rd    = xfer_to_dev;
                    mem_wr    = !xfer_to_dev;
                    mem_wdata = {8'h00, dev_rdata};
                    dev_wdata = xfer_to_dev ? rd_byte : 8'h00;
                    dev_ack   = 1'b1;
                    dev_eob   = dec.notify && last_byte;
                    step      = 1'b1;
                    if (last_byte) st_d = S_STORE;
                end
            end
            S_STORE: begin
                dev_store = 1'b1;
                mem_addr  = {list_hi, OFS_TYPE};
                mem_wr    = bus_gnt;
                mem_wdata = {8'h00, done_code(dev_status)};
                advance   = bus_gnt;
                if (bus_gnt) st_d = S_RD0;
            end
            default: st_d = S_IDLE;
        endcase
    end

endmodule

// File: rtl/ll_dma_channel.sv
module ll_dma_channel
    import lldma_pkg::*;
#(
    parameter int ADDR_W     = PKG_ADDR_W,
    parameter int LEN_W      = PKG_LEN_W,
    parameter int WORD_W     = PKG_WORD_W,
    parameter int DESC_BYTES = PKG_DESC_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic              run,
    input  logic              xfer_to_dev,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_wide,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              dev_req,
    input  logic              dev_term,
    output logic              dev_typefetch,
    output logic [5:0]        dev_cmd,
    output logic              dev_ack,
    output logic              dev_eob,
    output logic              dev_store,
    input  logic [6:0]        dev_status,
    output logic [7:0]        dev_wdata,
    input  logic [7:0]        dev_rdata
);
    localparam int ALIGN = $clog2(DESC_BYTES);

    logic [ADDR_W-1:ALIGN] list_hi;
    logic [ADDR_W-1:0]     buf_addr;
    logic [LEN_W-1:0]      remain;
    logic ld_lo, ld_hi, ld_len, step, link_load, advance, stop;

    lldma_lar #(.ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_lar (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .link_load (link_load),
        .link_addr (buf_addr[ADDR_W-1:ALIGN]),
        .advance   (advance),
        .stop      (stop),
        .list_hi   (list_hi),
        .run       (run)
    );

    lldma_bufctr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORD_W(WORD_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .ld_lo    (ld_lo),
        .ld_hi    (ld_hi),
        .ld_len   (ld_len),
        .step     (step),
        .word_in  (mem_rdata),
        .buf_addr (buf_addr),
        .remain   (remain)
    );

    lldma_seq #(.ADDR_W(ADDR_W), .ALIGN(ALIGN), .LEN_W(LEN_W), .WORD_W(WORD_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .run           (run),
        .list_hi       (list_hi),
        .buf_addr      (buf_addr),
        .remain        (remain),
        .xfer_to_dev   (xfer_to_dev),
        .bus_gnt       (bus_gnt),
        .rd_byte       (mem_rdata[7:0]),
        .dev_req       (dev_req),
        .dev_term      (dev_term),
        .dev_status    (dev_status),
        .dev_rdata     (dev_rdata),
        .bus_req       (bus_req),
        .mem_addr      (mem_addr),
        .mem_rd        (mem_rd),
        .mem_wr        (mem_wr),
        .mem_wide      (mem_wide),
        .mem_wdata     (mem_wdata),
        .dev_typefetch (dev_typefetch),
        .dev_cmd       (dev_cmd),
        .dev_ack       (dev_ack),
        .dev_eob       (dev_eob),
        .dev_store     (dev_store),
        .dev_wdata     (dev_wdata),
        .ld_lo         (ld_lo),
        .ld_hi         (ld_hi),
        .ld_len        (ld_len),
        .step          (step),
        .link_load     (link_load),
        .advance       (advance),
        .stop          (stop)
    );

endmodule

// File: rtl/lldma_checker.sv
module lldma_checker #(
    parameter int ADDR_W = 24,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic              run,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_wide,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              dev_req,
    input logic              dev_term,
    input logic              dev_typefetch,
    input logic              dev_ack,
    input logic              dev_eob,
    input logic              dev_store
);
    // R1: quiet outputs in the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!run && !bus_req && !dev_ack && !dev_store && !dev_typefetch));

    assert_run_on_top_lane_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == 2'd2 && !run) |=> run);

    assert_wide_even_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_wide && (mem_rd || mem_wr)) |-> (mem_addr[0] == 1'b0));

    assert_idle_no_bus_R4: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!bus_req && !mem_rd && !mem_wr));

    assert_typefetch_marks_R6: assert property (@(posedge clk) disable iff (rst)
        dev_typefetch |-> (mem_wr && mem_wide && mem_wdata == 16'h0004 && mem_addr[2:0] == 3'd4));

    assert_ack_needs_req_R7: assert property (@(posedge clk) disable iff (rst)
        dev_ack |-> dev_req);

    assert_eob_with_ack_R9: assert property (@(posedge clk) disable iff (rst)
        dev_eob |-> dev_ack);

    assert_term_blocks_ack_R10: assert property (@(posedge clk) disable iff (rst)
        dev_term |-> !dev_ack);

    assert_store_writes_code_R11: assert property (@(posedge clk) disable iff (rst)
        (dev_store && bus_gnt) |-> (mem_wr && mem_wide && mem_addr[2:0] == 3'd4 &&
                                    (mem_wdata == 16'h0005 || mem_wdata[15:6] == 10'b0000000011)));

    assert_cycle_needs_grant_R13: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> (bus_gnt && bus_req));

    assert_rw_exclusive_R13: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

endmodule

bind ll_dma_channel lldma_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_we        (reg_we),
    .reg_sel       (reg_sel),
    .run           (run),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .mem_addr      (mem_addr),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .mem_wide      (mem_wide),
    .mem_wdata     (mem_wdata),
    .dev_req       (dev_req),
    .dev_term      (dev_term),
    .dev_typefetch (dev_typefetch),
    .dev_ack       (dev_ack),
    .dev_eob       (dev_eob),
    .dev_store     (dev_store)
);

// File: tb/ll_dma_channel_test.sv
module ll_dma_channel_test;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_BYTES  = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic        run;
    logic        xfer_to_dev = 1'b0;
    logic        bus_req;
    logic        bus_gnt = 1'b1;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr, mem_wide;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        dev_req = 1'b0;
    logic        dev_term = 1'b0;
    logic        dev_typefetch;
    logic [5:0]  dev_cmd;
    logic        dev_ack, dev_eob, dev_store;
    logic [6:0]  dev_status = 7'd0;
    logic [7:0]  dev_wdata;
    logic [7:0]  dev_rdata;

    logic [7:0]  mem [0:MEM_BYTES-1];

    int n_chk = 0;
    int n_fail = 0;
    int n_ack, eob_n, eob_at, tf_n, store_n, bad_n, fa_n, cyc;
    int tf_cmd;
    int fa [0:7];
    logic [7:0] rx [0:15];
    bit gnt_stall = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ll_dma_channel uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .run(run), .xfer_to_dev(xfer_to_dev), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wide(mem_wide),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_req(dev_req), .dev_term(dev_term),
        .dev_typefetch(dev_typefetch), .dev_cmd(dev_cmd), .dev_ack(dev_ack), .dev_eob(dev_eob),
        .dev_store(dev_store), .dev_status(dev_status), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    // behavioural memory: combinational read, write at the clock edge
    assign mem_rdata = {mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]};
    // client data is a function of the target address: byte = addr[7:0] ^ 3C
    assign dev_rdata = mem_addr[7:0] ^ 8'h3C;

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[11:0]] <= mem_wdata[7:0];
            if (mem_wide) mem[mem_addr[11:0] + 12'd1] <= mem_wdata[15:8];
        end
    end

    // monitor: samples between the falling edge and the next rising edge
    always @(negedge clk) begin
        #3;
        cyc++;
        if (dev_ack) begin
            if (n_ack < 16) rx[n_ack] = dev_wdata;
            n_ack++;
            if (dev_eob) begin
                eob_n++;
                eob_at = n_ack;
            end
        end
        if (dev_typefetch) begin
            tf_n++;
            tf_cmd = int'(dev_cmd);
        end
        if (dev_store && bus_gnt) store_n++;
        if ((mem_rd || mem_wr) && !bus_gnt) bad_n++;
        if (mem_rd && mem_wide && mem_addr[2:0] == 3'd0 && fa_n < 8) begin
            fa[fa_n] = int'(mem_addr);
            fa_n++;
        end
    end

    always @(negedge clk) begin
        bus_gnt = gnt_stall ? ((cyc % 3) != 2) : 1'b1;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        n_ack = 0; eob_n = 0; eob_at = 0; tf_n = 0; tf_cmd = -1;
        store_n = 0; bad_n = 0; fa_n = 0;
        for (int i = 0; i < 8; i++) fa[i] = -1;
    endtask

    task automatic put_desc(input int base, input int baddr, input int tcode, input int len);
        mem[base]     = baddr[7:0];
        mem[base + 1] = baddr[15:8];
        mem[base + 2] = baddr[23:16];
        mem[base + 3] = 8'h00;
        mem[base + 4] = tcode[7:0];
        mem[base + 5] = 8'h00;
        mem[base + 6] = len[7:0];
        mem[base + 7] = len[15:8];
    endtask

    task automatic write_reg(input int sel, input int val);
        @(negedge clk);
        reg_we = 1'b1;
        reg_sel = sel[1:0];
        reg_wdata = val[7:0];
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic start(input int addr);
        write_reg(0, addr & 8'hFF);
        write_reg(1, (addr >> 8) & 8'hFF);
        write_reg(2, (addr >> 16) & 8'hFF);
    endtask

    task automatic wait_idle(input string tag);
        int k = 0;
        while (run && k < 3000) begin
            @(negedge clk);
            k++;
        end
        @(negedge clk);
        #4;
        check_eq({tag, " run drops"}, int'(run), 0);
    endtask

    initial begin
        for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'h00;
        clr_mon();
        cyc = 0;
        repeat (3) @(negedge clk);
        #4;
        check_eq("R1 run after reset", int'(run), 0);
        check_eq("R1 bus_req after reset", int'(bus_req), 0);
        check_eq("R1 strobes after reset",
                 int'({mem_rd, mem_wr, dev_ack, dev_typefetch, dev_eob, dev_store}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #4;
        check_eq("R1 run idle", int'(run), 0);

        // sweep: lengths 0..5, four type classes, both directions
        for (int len = 0; len < 6; len++) begin
            for (int t = 0; t < 4; t++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    int code, exp_cmd, notify, exp_code, mism, sv, sval;
                    code    = (t == 0) ? 8'h02 : (t == 1) ? 8'h03 : (t == 2) ? (8'h40 | (len * 9 + 1)) : (8'h80 | (len * 7 + dir + 5));
                    exp_cmd = (t >= 2) ? (code & 8'h3F) : 0;
                    notify  = (t == 1 || t == 3) ? 1 : 0;
                    sv      = (len + t + dir) % 2;
                    sval    = (len * 5 + t * 3 + dir) & 8'h3F;
                    exp_code = sv ? (8'hC0 | sval) : 8'h05;
                    put_desc(12'h100, dir ? 12'h400 : 12'h800, code, len);
                    put_desc(12'h108, 0, 8'h00, 0);
                    for (int i = 0; i < 8; i++) begin
                        mem[12'h400 + i] = 8'(i * 7 + len * 3 + t + 1);
                        mem[12'h800 + i] = 8'h00;
                    end
                    clr_mon();
                    xfer_to_dev = dir[0];
                    dev_status  = {sv[0], sval[5:0]};
                    dev_req     = 1'b1;
                    start(12'h100);
                    wait_idle("R4 sweep");
                    check_eq("R8 ack count", n_ack, len);
                    mism = 0;
                    for (int i = 0; i < len; i++) begin
                        if (dir == 1) begin
                            if (rx[i] != 8'(i * 7 + len * 3 + t + 1)) mism++;
                        end else begin
                            if (mem[12'h800 + i] != (8'(i) ^ 8'h3C)) mism++;
                        end
                    end
                    if (dir == 0 && mem[12'h800 + len] != 8'h00) mism++;
                    check_eq("R7 data moved", mism, 0);
                    check_eq("R6 typefetch count", tf_n, 1);
                    check_eq("R6 command bits", tf_cmd, exp_cmd);
                    check_eq("R9 eob count", eob_n, (notify && len > 0) ? 1 : 0);
                    if (notify && len > 0) check_eq("R9 eob on last byte", eob_at, len);
                    check_eq("R11 written code", int'(mem[12'h104]), exp_code);
                    check_eq("R11 store count", store_n, 1);
                    check_eq("R11 next fetch", fa[1], 12'h108);
                    check_eq("R4 end not rewritten", int'(mem[12'h10C]), 0);
                    check_eq("R3 fetch count", fa_n, 2);
                end
            end
        end

        // link, with start address low bits set
        put_desc(12'h300, 24'h000345, 8'h01, 0);
        put_desc(12'h340, 12'h400, 8'h02, 3);
        put_desc(12'h348, 0, 8'h00, 0);
        for (int i = 0; i < 3; i++) mem[12'h400 + i] = 8'(8'hA0 + i);
        clr_mon();
        xfer_to_dev = 1'b1;
        dev_status = 7'd0;
        dev_req = 1'b1;
        start(12'h306);
        wait_idle("R5 link");
        check_eq("R2 first fetch aligned", fa[0], 12'h300);
        check_eq("R5 link target", fa[1], 12'h340);
        check_eq("R5 after linked buffer", fa[2], 12'h348);
        check_eq("R5 link not rewritten", int'(mem[12'h304]), 1);
        check_eq("R5 bytes via link", n_ack, 3);
        check_eq("R5 byte value", int'(rx[2]), 8'hA2);

        // terminate after two bytes
        put_desc(12'h380, 12'h900, 8'h03, 6);
        put_desc(12'h388, 0, 8'h00, 0);
        for (int i = 0; i < 8; i++) mem[12'h900 + i] = 8'h00;
        clr_mon();
        xfer_to_dev = 1'b0;
        dev_status = 7'h55;
        dev_req = 1'b1;
        start(12'h380);
        while (n_ack < 2) @(negedge clk);
        dev_req = 1'b0;
        dev_term = 1'b1;
        @(negedge clk);
        dev_term = 1'b0;
        wait_idle("R10 term");
        check_eq("R10 bytes before terminate", n_ack, 2);
        check_eq("R10 no eob on terminate", eob_n, 0);
        check_eq("R10 third byte untouched", int'(mem[12'h902]), 0);
        check_eq("R11 status code", int'(mem[12'h384]), 8'hD5);
        check_eq("R11 next after terminate", fa[1], 12'h388);

        // grant stalls
        put_desc(12'h3A0, 12'h400, 8'h80, 4);
        put_desc(12'h3A8, 0, 8'h00, 0);
        for (int i = 0; i < 4; i++) mem[12'h400 + i] = 8'(8'h11 * (i + 1));
        clr_mon();
        xfer_to_dev = 1'b1;
        dev_status = 7'h00;
        dev_req = 1'b1;
        gnt_stall = 1'b1;
        start(12'h3A0);
        wait_idle("R13 stall");
        gnt_stall = 1'b0;
        check_eq("R13 cycles without grant", bad_n, 0);
        check_eq("R13 bytes under stall", n_ack, 4);
        check_eq("R13 data under stall", int'(rx[3]), 8'h44);
        check_eq("R13 code under stall", int'(mem[12'h3A4]), 5);
        check_eq("R13 eob under stall", eob_n, 1);

        // register writes while running are ignored
        put_desc(12'h3C0, 12'h800, 8'h02, 2);
        put_desc(12'h3C8, 0, 8'h00, 0);
        clr_mon();
        xfer_to_dev = 1'b0;
        dev_req = 1'b0;
        start(12'h3C0);
        repeat (12) @(negedge clk);
        write_reg(0, 8'h55);
        write_reg(1, 8'h0A);
        write_reg(2, 8'h0B);
        dev_req = 1'b1;
        wait_idle("R12 busy writes");
        check_eq("R12 list address kept", fa[1], 12'h3C8);
        check_eq("R12 bytes", n_ack, 2);

        // undefined codes end the chain without write-back
        for (int k = 0; k < 5; k++) begin
            int code;
            code = (k == 0) ? 8'h06 : (k == 1) ? 8'h04 : (k == 2) ? 8'h05 : (k == 3) ? 8'hC7 : 8'h20;
            put_desc(12'h3E0, 12'h400, code, 3);
            clr_mon();
            dev_req = 1'b1;
            start(12'h3E0);
            wait_idle("R4 undefined");
            check_eq("R4 code kept", int'(mem[12'h3E4]), code);
            check_eq("R4 no typefetch", tf_n, 0);
            check_eq("R4 single fetch", fa_n, 1);
            check_eq("R4 bus released", int'(bus_req), 0);
        end

        summary();
    end

endmodule